// File: doc/BRIEF.md
# Cascadable Ripple Magnitude Comparator

This block compares two unsigned operands of a configurable width and reports whether the first is greater than, equal to or less than the second. It has no clock and no state. The comparison is a chain of identical one-bit cells. The chain starts at the least significant bit and ends at the most significant bit. Each cell passes a greater flag and a less flag to the cell above it. A cell whose two bits differ overrides whatever comes from below. A cell whose two bits match passes the incoming flags through unchanged. The three outputs are taken from the top cell of the chain.

Two cascade inputs feed the bottom cell. A stand-alone comparator ties both cascade inputs low. To build a wider comparator, connect the greater and less outputs of the low-order instance to the cascade inputs of the high-order instance. The equal output is not computed by a separate equality tree. It is derived in the top cell from its own bit pair and the two flags arriving from below.

Top module: `mag_cmp_ripple`

## Requirements
- R1: Cell greater rule. A cell drives greater high when its a bit is 1 and its b bit is 0. It also drives greater high when its two bits match and its incoming greater flag is 1. At WIDTH 1 this is the gt_o rule.
- R2: Cell less rule. A cell drives less high when its a bit is 0 and its b bit is 1. It also drives less high when its two bits match and its incoming less flag is 1. At WIDTH 1 this is the lt_o rule.
- R3: eq_o is 1 exactly when a_i equals b_i and both casc_gt_i and casc_lt_i are 0.
- R4: When a_i differs from b_i, the cascade inputs have no effect: gt_o equals (a_i > b_i) and lt_o equals (a_i < b_i), as unsigned values.
- R5: When a_i equals b_i, gt_o equals casc_gt_i and lt_o equals casc_lt_i.
- R6: When casc_gt_i and casc_lt_i are not both 1, exactly one of gt_o, eq_o and lt_o is 1.
- R7: When both cascade inputs are 1 and the operands are equal, gt_o and lt_o are both 1 and eq_o is 0.
- R8: Two WIDTH-4 instances form an 8-bit unsigned comparator. The lower instance has both cascade inputs at 0. Its gt_o and lt_o drive the casc_gt_i and casc_lt_i of the upper instance. The upper instance's outputs then give the 8-bit result.
- R9: With cascade inputs at 0 and WIDTH 4, the following results hold: a=1101, b=0110 gives gt_o; a=1011, b=1011 gives eq_o; a=0101, b=0111 gives lt_o.
- R10: WIDTH defaults to 4 and may be any value of at least 1. At WIDTH 1 the block behaves as a single cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| casc_gt_i | input | 1 | Greater flag from a lower-order stage; 0 when none is attached |
| casc_lt_i | input | 1 | Less flag from a lower-order stage; 0 when none is attached |
| gt_o | output | 1 | a_i greater than b_i, taking the cascade flags into account |
| eq_o | output | 1 | a_i equal to b_i and neither cascade flag set |
| lt_o | output | 1 | a_i less than b_i, taking the cascade flags into account |

## Verification
The assertions only evaluate when every operand bit and cascade bit is a known 0 or 1. The one-hot property is enforced only when the cascade pair is not 1,1. The bench starts with all inputs at 0 and never drives X or Z. It sweeps every cascade pair, including 1,1, over all WIDTH-4 operand pairs. In that sweep the 1,1 case is checked against its own rule, R7. The random 8-bit vectors drive the chained pair with cascade inputs at 0, which is the only legal stand-alone setting.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  typedef struct packed {
    logic gt;
    logic lt;
  } cmp_flags_t;

  function automatic cmp_flags_t cell_step(input logic x, input logic y, input cmp_flags_t below);
    cmp_flags_t res;
    logic       same;
    same   = ~(x ^ y);
    res.gt = (x & ~y) | (same & below.gt);
    res.lt = (~x & y) | (same & below.lt);
    return res;
  endfunction

  function automatic logic cell_equal(input logic x, input logic y, input cmp_flags_t below);
    return ~(x ^ y) & ~below.gt & ~below.lt;
  endfunction

endpackage

// File: rtl/cmp_cell.sv
module cmp_cell
  import cmp_pkg::*;
(
  input  logic       x_i,
  input  logic       y_i,
  input  cmp_flags_t below_i,
  output cmp_flags_t above_o,
  output logic       eq_o
);

  always_comb begin
    above_o = cell_step(x_i, y_i, below_i);
    eq_o    = cell_equal(x_i, y_i, below_i);
  end

endmodule

// File: rtl/cmp_chain.sv
module cmp_chain
  import cmp_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             gt_in_i,
  input  logic             lt_in_i,
  output logic [WIDTH:0]   gt_chain_o,
  output logic [WIDTH:0]   lt_chain_o,
  output logic [WIDTH-1:0] eq_vec_o
);

  cmp_flags_t link [WIDTH+1];

  assign link[0].gt = gt_in_i;
  assign link[0].lt = lt_in_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    cmp_cell u_cell (
      .x_i     (a_i[i]),
      .y_i     (b_i[i]),
      .below_i (link[i]),
      .above_o (link[i+1]),
      .eq_o    (eq_vec_o[i])
    );
  end

  for (genvar j = 0; j <= WIDTH; j++) begin : g_tap
    assign gt_chain_o[j] = link[j].gt;
    assign lt_chain_o[j] = link[j].lt;
  end

endmodule

// File: rtl/mag_cmp_ripple.sv
module mag_cmp_ripple #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             casc_gt_i,
  input  logic             casc_lt_i,
  output logic             gt_o,
  output logic             eq_o,
  output logic             lt_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   gt_chain;
  logic [WIDTH:0]   lt_chain;
  logic [WIDTH-1:0] eq_vec;

  cmp_chain #(.WIDTH(WIDTH)) u_chain (
    .a_i        (a_i),
    .b_i        (b_i),
    .gt_in_i    (casc_gt_i),
    .lt_in_i    (casc_lt_i),
    .gt_chain_o (gt_chain),
    .lt_chain_o (lt_chain),
    .eq_vec_o   (eq_vec)
  );

  assign gt_o = gt_chain[WIDTH];
  assign lt_o = lt_chain[WIDTH];
  assign eq_o = eq_vec[MSB];

endmodule

// File: rtl/mag_cmp_ripple_chk.sv
module mag_cmp_ripple_chk #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             casc_gt_i,
  input logic             casc_lt_i,
  input logic             gt_o,
  input logic             eq_o,
  input logic             lt_o,
  input logic [WIDTH:0]   gt_chain,
  input logic [WIDTH:0]   lt_chain,
  input logic [WIDTH-1:0] eq_vec
);

  logic known;
  assign known = !$isunknown({a_i, b_i, casc_gt_i, casc_lt_i});

  always_comb begin
    if (known) begin
      p_eq_rule_r3: assert (eq_o == ((a_i == b_i) && !casc_gt_i && !casc_lt_i));
      if (a_i != b_i) begin
        p_unequal_ignores_casc_r4: assert (gt_o == (a_i > b_i) && lt_o == (a_i < b_i));
      end else begin
        p_equal_passes_casc_r5: assert (gt_o == casc_gt_i && lt_o == casc_lt_i);
      end
      if (!(casc_gt_i && casc_lt_i)) begin
        p_one_result_r6: assert ($countones({gt_o, eq_o, lt_o}) == 1);
      end
      if (casc_gt_i && casc_lt_i && (a_i == b_i)) begin
        p_both_casc_r7: assert (gt_o && lt_o && !eq_o);
      end
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_cellchk
    always_comb begin
      if (known) begin
        if (a_i[i] != b_i[i]) begin
          p_cell_gt_override_r1: assert (gt_chain[i+1] == a_i[i]);
          p_cell_lt_override_r2: assert (lt_chain[i+1] == b_i[i]);
        end else begin
          p_cell_gt_pass_r1: assert (gt_chain[i+1] == gt_chain[i]);
          p_cell_lt_pass_r2: assert (lt_chain[i+1] == lt_chain[i]);
        end
        if (eq_vec[i]) begin
          p_cell_eq_excl_r3: assert (!gt_chain[i+1] && !lt_chain[i+1]);
        end
      end
    end
  end

endmodule

bind mag_cmp_ripple mag_cmp_ripple_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .casc_gt_i (casc_gt_i),
  .casc_lt_i (casc_lt_i),
  .gt_o      (gt_o),
  .eq_o      (eq_o),
  .lt_o      (lt_o),
  .gt_chain  (gt_chain),
  .lt_chain  (lt_chain),
  .eq_vec    (eq_vec)
);

// File: tb/mag_cmp_ripple_tb.sv
module mag_cmp_ripple_tb;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // width-4 device
  logic [3:0] a4 = '0, b4 = '0;
  logic       cg4 = 1'b0, cl4 = 1'b0;
  logic       gt4, eq4, lt4;

  mag_cmp_ripple #(.WIDTH(4)) u_dut (
    .a_i(a4), .b_i(b4), .casc_gt_i(cg4), .casc_lt_i(cl4),
    .gt_o(gt4), .eq_o(eq4), .lt_o(lt4)
  );

  // chained 8-bit pair
  logic [7:0] a8 = '0, b8 = '0;
  logic       lo_gt, lo_eq, lo_lt, hi_gt, hi_eq, hi_lt;

  mag_cmp_ripple #(.WIDTH(4)) u_lo (
    .a_i(a8[3:0]), .b_i(b8[3:0]), .casc_gt_i(1'b0), .casc_lt_i(1'b0),
    .gt_o(lo_gt), .eq_o(lo_eq), .lt_o(lo_lt)
  );
  mag_cmp_ripple #(.WIDTH(4)) u_hi (
    .a_i(a8[7:4]), .b_i(b8[7:4]), .casc_gt_i(lo_gt), .casc_lt_i(lo_lt),
    .gt_o(hi_gt), .eq_o(hi_eq), .lt_o(hi_lt)
  );

  // width-1 device
  logic a1 = 1'b0, b1 = 1'b0, cg1 = 1'b0, cl1 = 1'b0;
  logic gt1, eq1, lt1;

  mag_cmp_ripple #(.WIDTH(1)) u_one (
    .a_i(a1), .b_i(b1), .casc_gt_i(cg1), .casc_lt_i(cl1),
    .gt_o(gt1), .eq_o(eq1), .lt_o(lt1)
  );

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {gt,eq,lt} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] expect4(input int a, input int b, input logic cg, input logic cl);
    if (a > b)      return 3'b100;
    else if (a < b) return 3'b001;
    else            return {cg, ~cg & ~cl, cl};
  endfunction

  initial begin
    #5;
    check("R3 initial zeros", {gt4, eq4, lt4}, 3'b010);

    // R9 directed examples
    a4 = 4'b1101; b4 = 4'b0110; #10; check("R9 1101 vs 0110", {gt4, eq4, lt4}, 3'b100);
    a4 = 4'b1011; b4 = 4'b1011; #10; check("R9 1011 vs 1011", {gt4, eq4, lt4}, 3'b010);
    a4 = 4'b0101; b4 = 4'b0111; #10; check("R9 0101 vs 0111", {gt4, eq4, lt4}, 3'b001);

    // exhaustive width 4 over every cascade pair: R3 R4 R5 R6 R7
    for (int c = 0; c < 4; c++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          a4 = a[3:0]; b4 = b[3:0]; cg4 = c[1]; cl4 = c[0];
          #10;
          if (a != b)
            check("R4 unequal ignores cascade", {gt4, eq4, lt4}, expect4(a, b, c[1], c[0]));
          else if (c == 3)
            check("R7 equal with both cascade set", {gt4, eq4, lt4}, 3'b101);
          else
            check("R5 R3 R6 equal passes cascade", {gt4, eq4, lt4}, expect4(a, b, c[1], c[0]));
        end
      end
    end

    // width 1 single cell exhaustive: R1 R2 R10
    for (int v = 0; v < 16; v++) begin
      a1 = v[3]; b1 = v[2]; cg1 = v[1]; cl1 = v[0];
      #10;
      check("R1 cell greater rule", gt1, (v[3] & ~v[2]) | ((v[3] == v[2]) & v[1]));
      check("R2 cell less rule", lt1, (~v[3] & v[2]) | ((v[3] == v[2]) & v[0]));
      check("R10 width1 equal", eq1, (v[3] == v[2]) & ~v[1] & ~v[0]);
    end

    // chained 8-bit: R8 directed boundaries then random
    a8 = 8'h00; b8 = 8'h00; #10; check("R8 chain 00 vs 00", {hi_gt, hi_eq, hi_lt}, 3'b010);
    a8 = 8'hFF; b8 = 8'h00; #10; check("R8 chain FF vs 00", {hi_gt, hi_eq, hi_lt}, 3'b100);
    a8 = 8'h5A; b8 = 8'h5B; #10; check("R8 chain low nibble decides", {hi_gt, hi_eq, hi_lt}, 3'b001);
    a8 = 8'h4F; b8 = 8'h50; #10; check("R8 chain high nibble wins", {hi_gt, hi_eq, hi_lt}, 3'b001);
    for (int k = 0; k < 3000; k++) begin
      logic [7:0] ra, rb;
      ra = 8'($urandom);
      rb = (k % 5 == 0) ? ra : 8'($urandom);
      if (k % 7 == 0) rb = {ra[7:4], 4'($urandom)};
      a8 = ra; b8 = rb;
      #10;
      check("R8 chained random", {hi_gt, hi_eq, hi_lt},
            {ra > rb, ra == rb, ra < rb});
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule